// File: doc/BRIEF.md
# Instrument Status Reporting Hierarchy

This block collects the status of a programmable instrument into a tree of registers that a host reads over a simple register port. Three condition groups feed the tree. The operation group is 16 bits wide and holds normal-operation states. The questionable group is 16 bits wide and holds data-quality states. The standard event group is 8 bits wide. Each group samples its condition inputs into a register. A rising edge on a condition bit is latched into that group's event register, but only when the matching bit of the group's enable register is set. Reading an event register returns its contents and clears it.

Each group reduces its event register to a single summary bit. These summary bits form the 8-bit status byte, together with two external flags: error queue not empty and output message available. The status byte is masked by a service-request enable register. The OR of the masked bits, with bit 6 left out, becomes status byte bit 6. That bit also drives the service-request output to the host.

Top module: `status_summary_unit`

## Requirements
- R1: After reset, every register reads zero and `srqOut` is 0.
- R2: An event bit is set only by a 0-to-1 change of its condition bit while the matching enable bit is 1. A change on a condition input reaches the event register at the second rising clock edge after it is applied. A held level or a falling edge sets nothing. An edge that arrives while the enable bit is 0 is lost, even if the enable bit is set later.
- R3: A read (`rdEn`=1) of an event address returns the current event contents on `rdData` in the same cycle and clears the register at the next clock edge. If a qualifying edge lands on that same edge, its bit survives the clear.
- R4: The address map (4-bit `addr`) is as follows. Operation group: 0 = condition, 1 = event, 2 = enable. Questionable group: 3 = condition, 4 = event, 5 = enable. Standard event group: 6 = condition, 7 = event, 8 = enable. Address 9 is the status byte and address 10 is the service-request enable. Only the enable addresses (2, 5, 8, 10) accept writes. A write to any other address has no effect. Enable registers read back what was written. 8-bit values are zero-extended on `rdData`.
- R5: Status byte bits are assigned as follows. Bit 7 is the OR of the operation event register. Bit 5 is the OR of the standard event register. Bit 3 is the OR of the questionable event register. Bit 4 is the message-available flag and bit 2 is the error-queue flag, each visible one clock edge after the input changes. Bits 0 and 1 are always 0.
- R6: Status byte bit 6 is the OR of (status byte AND service-request enable) over every bit except bit 6. `srqOut` equals that bit. Enable bit 6 has no effect.
- R7: Operation condition bits other than 8, 9 and 10 (constant voltage, relay closed, constant current) always read 0 and never set an event bit.
- R8: Questionable condition bit 10 (current mode) never sets its event bit, whatever its enable bit holds. It still reads back on the condition address.
- R9: A read of a condition address returns the registered condition, one clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oprCond | input | 16 | Operation condition inputs |
| quesCond | input | 16 | Questionable condition inputs |
| stdCond | input | 8 | Standard event condition inputs |
| errQueueNotEmpty | input | 1 | Error queue holds at least one entry |
| msgAvail | input | 1 | Output message available |
| rdEn | input | 1 | Read strobe; event reads clear |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid while rdEn is high |
| srqOut | output | 1 | Service request to host |

## Verification
The questionable group is driven with a set of enable and condition pairs: all enabled, partially enabled, none enabled, alternating masks, and patterns that touch the current-mode bit. These separate a correct edge-and-enable gate from one that ignores the mask, ignores the bit exclusion, or latches levels. Directed sequences hold a level, drop it, and enable a bit only after its edge has passed. Together they tell edge capture apart from level capture, and gating before the latch apart from masking afterwards. The status byte is built from each source in turn and tested against several service-request masks, including a mask of only bit 6. A read that coincides with a new edge shows whether the clear can lose an event.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int ADDR_W = 4;
  localparam int BUS_W  = 16;
  localparam int STB_W  = 8;

  // status byte bit positions
  localparam int ERRQ_BIT = 2;
  localparam int QUES_BIT = 3;
  localparam int MSG_BIT  = 4;
  localparam int STD_BIT  = 5;
  localparam int SRQ_BIT  = 6;
  localparam int OPR_BIT  = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_OPR_COND  = 4'd0,
    A_OPR_EVT   = 4'd1,
    A_OPR_EN    = 4'd2,
    A_QUES_COND = 4'd3,
    A_QUES_EVT  = 4'd4,
    A_QUES_EN   = 4'd5,
    A_STD_COND  = 4'd6,
    A_STD_EVT   = 4'd7,
    A_STD_EN    = 4'd8,
    A_STB       = 4'd9,
    A_SRE       = 4'd10
  } regAddr_e;

  typedef struct packed {
    logic     clrOpr;
    logic     clrQues;
    logic     clrStd;
    logic     wrOprEn;
    logic     wrQuesEn;
    logic     wrStdEn;
    logic     wrSre;
    logic     rdValid;
    regAddr_e rdSel;
  } strobe_t;

endpackage

// File: rtl/stat_group.sv
module stat_group #(
  parameter int          W         = 16,
  parameter logic [W-1:0] COND_MASK = '1,
  parameter logic [W-1:0] CAP_MASK  = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] condIn,
  input  logic         enWr,
  input  logic [W-1:0] enData,
  input  logic         evtClr,
  output logic [W-1:0] condQ,
  output logic [W-1:0] evtReg,
  output logic [W-1:0] enReg,
  output logic [W-1:0] edgeQual
);

  logic [W-1:0] condPrev;
  logic [W-1:0] evtNext;

  // per-bit capture: rising edge, enabled, and allowed by the capture mask
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (CAP_MASK[b]) begin : g_cap
      assign edgeQual[b] = condQ[b] & ~condPrev[b] & enReg[b];
    end else begin : g_nocap
      assign edgeQual[b] = 1'b0 & condPrev[b];
    end
  end

  always_comb begin
    evtNext = evtReg;
    if (evtClr) evtNext = '0;
    evtNext = evtNext | edgeQual;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ    <= '0;
      condPrev <= '0;
      evtReg   <= '0;
      enReg    <= '0;
    end else begin
      condQ    <= condIn & COND_MASK;
      condPrev <= condQ;
      evtReg   <= evtNext;
      if (enWr) enReg <= enData;
    end
  end

endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import stat_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);

  regAddr_e sel;

  assign sel = regAddr_e'(addr);

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.rdValid  = rdEn;
    if (rdEn) begin
      unique case (sel)
        A_OPR_EVT:  strb.clrOpr  = 1'b1;
        A_QUES_EVT: strb.clrQues = 1'b1;
        A_STD_EVT:  strb.clrStd  = 1'b1;
        default: ;
      endcase
    end
    if (wrEn) begin
      unique case (sel)
        A_OPR_EN:  strb.wrOprEn  = 1'b1;
        A_QUES_EN: strb.wrQuesEn = 1'b1;
        A_STD_EN:  strb.wrStdEn  = 1'b1;
        A_SRE:     strb.wrSre    = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import stat_pkg::*;
#(
  parameter int               OPR_W     = 16,
  parameter int               QUES_W    = 16,
  parameter int               STD_W     = 8,
  parameter logic [OPR_W-1:0] OPR_MASK  = 16'h0700,
  parameter logic [QUES_W-1:0] QUES_CAP = 16'hFBFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [OPR_W-1:0]  oprCond,
  input  logic [QUES_W-1:0] quesCond,
  input  logic [STD_W-1:0]  stdCond,
  input  logic              errQueueNotEmpty,
  input  logic              msgAvail,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic [OPR_W-1:0]  oprEvt,
  output logic [QUES_W-1:0] quesEvt,
  output logic [QUES_W-1:0] quesEn,
  output logic [QUES_W-1:0] quesEdge,
  output logic [STB_W-1:0]  statusByte,
  output logic [STB_W-1:0]  sreReg,
  output logic              srqOut
);

  localparam logic [STB_W-1:0] SRQ_EXCL = ~(STB_W'(1) << SRQ_BIT);

  logic [OPR_W-1:0]  oprCondQ, oprEn, oprEdge;
  logic [QUES_W-1:0] quesCondQ;
  logic [STD_W-1:0]  stdCondQ, stdEvt, stdEn, stdEdge;
  logic              flagErrQ, flagMsg;
  logic [STB_W-1:0]  stbBase;
  logic              srqBit;

  stat_group #(.W(OPR_W), .COND_MASK(OPR_MASK), .CAP_MASK(OPR_MASK)) i_opr (
    .clk, .rstN,
    .condIn(oprCond), .enWr(strb.wrOprEn), .enData(wrData[OPR_W-1:0]),
    .evtClr(strb.clrOpr), .condQ(oprCondQ), .evtReg(oprEvt),
    .enReg(oprEn), .edgeQual(oprEdge)
  );

  stat_group #(.W(QUES_W), .COND_MASK('1), .CAP_MASK(QUES_CAP)) i_ques (
    .clk, .rstN,
    .condIn(quesCond), .enWr(strb.wrQuesEn), .enData(wrData[QUES_W-1:0]),
    .evtClr(strb.clrQues), .condQ(quesCondQ), .evtReg(quesEvt),
    .enReg(quesEn), .edgeQual(quesEdge)
  );

  stat_group #(.W(STD_W), .COND_MASK('1), .CAP_MASK('1)) i_std (
    .clk, .rstN,
    .condIn(stdCond), .enWr(strb.wrStdEn), .enData(wrData[STD_W-1:0]),
    .evtClr(strb.clrStd), .condQ(stdCondQ), .evtReg(stdEvt),
    .enReg(stdEn), .edgeQual(stdEdge)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagErrQ <= 1'b0;
      flagMsg  <= 1'b0;
      sreReg   <= '0;
    end else begin
      flagErrQ <= errQueueNotEmpty;
      flagMsg  <= msgAvail;
      if (strb.wrSre) sreReg <= wrData[STB_W-1:0];
    end
  end

  always_comb begin
    stbBase           = '0;
    stbBase[ERRQ_BIT] = flagErrQ;
    stbBase[QUES_BIT] = |quesEvt;
    stbBase[MSG_BIT]  = flagMsg;
    stbBase[STD_BIT]  = |stdEvt;
    stbBase[OPR_BIT]  = |oprEvt;
    srqBit            = |(stbBase & sreReg & SRQ_EXCL);
    statusByte        = stbBase;
    statusByte[SRQ_BIT] = srqBit;
  end

  assign srqOut = srqBit;

  always_comb begin
    rdData = '0;
    if (strb.rdValid) begin
      unique case (strb.rdSel)
        A_OPR_COND:  rdData = BUS_W'(oprCondQ);
        A_OPR_EVT:   rdData = BUS_W'(oprEvt);
        A_OPR_EN:    rdData = BUS_W'(oprEn);
        A_QUES_COND: rdData = BUS_W'(quesCondQ);
        A_QUES_EVT:  rdData = BUS_W'(quesEvt);
        A_QUES_EN:   rdData = BUS_W'(quesEn);
        A_STD_COND:  rdData = BUS_W'(stdCondQ);
        A_STD_EVT:   rdData = BUS_W'(stdEvt);
        A_STD_EN:    rdData = BUS_W'(stdEn);
        A_STB:       rdData = BUS_W'(statusByte);
        A_SRE:       rdData = BUS_W'(sreReg);
        default:     rdData = '0;
      endcase
    end
  end

  logic unusedEdges;
  assign unusedEdges = ^{oprEdge, stdEdge};

endmodule

// File: rtl/status_summary_unit.sv
module status_summary_unit
  import stat_pkg::*;
#(
  parameter int OPR_W  = 16,
  parameter int QUES_W = 16,
  parameter int STD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPR_W-1:0]  oprCond,
  input  logic [QUES_W-1:0] quesCond,
  input  logic [STD_W-1:0]  stdCond,
  input  logic              errQueueNotEmpty,
  input  logic              msgAvail,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              srqOut
);

  strobe_t           strb;
  logic [OPR_W-1:0]  oprEvt;
  logic [QUES_W-1:0] quesEvt, quesEn, quesEdge;
  logic [STB_W-1:0]  statusByte, sreReg;

  stat_ctrl i_ctrl (.rdEn, .wrEn, .addr, .strb);

  stat_datapath #(.OPR_W(OPR_W), .QUES_W(QUES_W), .STD_W(STD_W)) i_dp (
    .clk, .rstN, .strb,
    .oprCond, .quesCond, .stdCond, .errQueueNotEmpty, .msgAvail,
    .wrData, .rdData,
    .oprEvt, .quesEvt, .quesEn, .quesEdge, .statusByte, .sreReg, .srqOut
  );

endmodule

// File: rtl/stat_checker.sv
module stat_checker (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [3:0]  addr,
  input logic [15:0] oprEvt,
  input logic [15:0] quesEvt,
  input logic [15:0] quesEn,
  input logic [15:0] quesEdge,
  input logic [7:0]  statusByte,
  input logic [7:0]  sreReg,
  input logic        srqOut
);

  // R2: a newly set event bit must have been enabled on the previous cycle
  a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (quesEvt & ~$past(quesEvt) & ~$past(quesEn)) == 16'h0);

  // R3: after a read of the event address only same-edge captures remain
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && addr == 4'd4) |-> quesEvt == $past(quesEdge));

  // R5: any questionable event raises status byte bit 3
  a_r5_ques_summary: assert property (@(posedge clk) disable iff (!rstN)
    (|quesEvt) |-> statusByte[3]);

  // R6: an empty service-request mask never requests service
  a_r6_no_srq_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (sreReg == 8'h00) |-> !srqOut);

  // R7: unused operation bits never hold events
  a_r7_opr_unused: assert property (@(posedge clk) disable iff (!rstN)
    (oprEvt & 16'hF8FF) == 16'h0);

  // R8: current-mode bit never latches
  a_r8_bit10_excluded: assert property (@(posedge clk) disable iff (!rstN)
    !quesEvt[10]);

endmodule

bind status_summary_unit stat_checker i_chk (.*);

// File: tb/test_status_summary_unit.sv
module test_status_summary_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {enable, condition, expected event}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hFFFF, 16'h0001, 16'h0001},
    {16'h00FF, 16'h0F0F, 16'h000F},
    {16'hFFFF, 16'h0400, 16'h0000},
    {16'hFFFF, 16'h4700, 16'h4300},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'hAAAA, 16'hFFFF, 16'hAAAA}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] oprCond = 0, quesCond = 0;
  logic [7:0]  stdCond = 0;
  logic        errQueueNotEmpty = 0, msgAvail = 0;
  logic        rdEn = 0, wrEn = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;
  logic        srqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_summary_unit i_status_summary_unit (
    .clk, .rstN, .oprCond, .quesCond, .stdCond, .errQueueNotEmpty, .msgAvail,
    .rdEn, .wrEn, .addr, .wrData, .rdData, .srqOut
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; addr = 0; wrData = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [15:0] v);
    rdEn = 1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 0; addr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    waitN(3);
    rstN = 1;
    waitN(1);

    // R1: reset state on every address
    for (int a = 0; a <= 10; a++) begin
      regRead(4'(a), v);
      check($sformatf("R1 reset addr %0d", a), v, 16'h0);
    end
    check("R1 srq reset", {15'h0, srqOut}, 16'h0);

    // R2 R8: vector walk on the questionable group
    for (int i = 0; i < NVEC; i++) begin
      regWrite(4'd5, VEC[i][47:32]);
      quesCond = 0;
      waitN(3);
      regRead(4'd4, v);
      quesCond = VEC[i][31:16];
      waitN(3);
      regRead(4'd4, v);
      check($sformatf("R2 R8 vector %0d", i), v, VEC[i][15:0]);
    end
    // R8: bit 10 still visible as condition
    regRead(4'd3, v);
    check("R8 ques cond readback", v, 16'hFFFF);
    regRead(4'd5, v);
    check("R4 ques enable readback", v, 16'hAAAA);
    quesCond = 0;
    waitN(3);
    regRead(4'd4, v);

    // R7 R9: operation group masking
    regWrite(4'd2, 16'hFFFF);
    oprCond = 16'hFFFF;
    @(negedge clk);
    regRead(4'd0, v);
    check("R9 R7 opr cond one edge later", v, 16'h0700);
    waitN(1);
    regRead(4'd1, v);
    check("R2 R7 opr event", v, 16'h0700);
    regRead(4'd1, v);
    check("R3 opr event cleared", v, 16'h0000);
    waitN(3);
    regRead(4'd1, v);
    check("R2 held level no event", v, 16'h0000);
    oprCond = 0;
    waitN(3);
    regRead(4'd1, v);
    check("R2 falling edge no event", v, 16'h0000);

    // R2: edge with enable off is lost even if enabled later
    regWrite(4'd5, 16'h0000);
    quesCond = 16'h0002;
    waitN(3);
    regWrite(4'd5, 16'hFFFF);
    waitN(2);
    regRead(4'd4, v);
    check("R2 late enable", v, 16'h0000);
    quesCond = 0;
    waitN(3);

    // R4: writes to non-enable addresses ignored
    regWrite(4'd9, 16'hFFFF);
    regWrite(4'd4, 16'hFFFF);
    regWrite(4'd12, 16'hFFFF);
    regRead(4'd9, v);
    check("R4 status byte write ignored", v, 16'h0000);
    regRead(4'd4, v);
    check("R4 event write ignored", v, 16'h0000);
    regRead(4'd10, v);
    check("R4 sre untouched", v, 16'h0000);

    // R5: build the status byte
    regWrite(4'd8, 16'h00FF);
    stdCond = 8'h21;
    oprCond = 16'h0100;
    quesCond = 16'h0001;
    errQueueNotEmpty = 1;
    msgAvail = 1;
    waitN(3);
    regRead(4'd9, v);
    check("R5 status byte all sources", v, 16'h00BC);
    check("R6 srq with empty mask", {15'h0, srqOut}, 16'h0);
    regRead(4'd7, v);
    check("R5 std event", v, 16'h0021);
    regRead(4'd9, v);
    check("R5 std summary cleared", v, 16'h009C);

    // R6: service request masking
    regWrite(4'd10, 16'h0040);
    #1 check("R6 bit6 enable ignored", {15'h0, srqOut}, 16'h0);
    @(negedge clk);
    regWrite(4'd10, 16'h0010);
    #1 check("R6 msg enabled srq", {15'h0, srqOut}, 16'h1);
    @(negedge clk);
    regRead(4'd9, v);
    check("R6 bit6 in status byte", v, 16'h00DC);
    msgAvail = 0;
    waitN(1);
    check("R5 R6 msg flag dropped", {15'h0, srqOut}, 16'h0);
    regWrite(4'd10, 16'h0080);
    #1 check("R6 opr enabled srq", {15'h0, srqOut}, 16'h1);
    @(negedge clk);
    regRead(4'd1, v);
    check("R3 opr read returns", v, 16'h0100);
    #1 check("R3 R6 srq drops after clear", {15'h0, srqOut}, 16'h0);
    @(negedge clk);

    // R3: read and a new edge on the same clock edge
    regRead(4'd4, v);
    check("R5 ques event source", v, 16'h0001);
    quesCond = 16'h0021;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1; addr = 4'd4;
    #1 v = rdData;
    check("R3 read before coinciding edge", v, 16'h0000);
    @(negedge clk);
    rdEn = 0; addr = 0;
    regRead(4'd4, v);
    check("R3 edge survives clear", v, 16'h0020);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule